// File: doc/BRIEF.md
# Weighted Round-Robin Cell Scheduler

This block decides which of several output queues may send the next cell. The queues get their turns in a fixed cyclic order. When a queue holds the turn, it may send up to a programmable number of cells, set by its weight. The scheduler sees only a non-empty flag for each queue, an 8-bit weight for each queue, and a strobe that marks each completed cell. It reports the index of the queue being served and a flag that says this index is valid. Cell storage, the datapath and the conversion of fractional shares into integer weights all live outside the block.

A queue with nothing to send, or with a weight of zero, is passed over when the search for the next turn reaches it. The cells it would have sent in a round go to the queues that are still active. Each of those queues keeps its own burst size, so the freed capacity is shared in proportion to the weights. A turn ends early if its queue runs dry. Credit left over from a turn is discarded.

Top module: `wrr_sched`

## Requirements
- R1: While reset is high, and after it is released, `serve_valid` is 0 until a turn is granted. The first search after reset starts at queue 0.
- R2: Queues are visited in increasing index order, and the search wraps from queue NUM_Q-1 to queue 0. The next turn goes to the first eligible queue after the last queue that held a turn. The last holder itself is considered last, so a lone eligible queue receives back-to-back turns.
- R3: A queue is eligible when its bit in `q_busy` is 1 and its weight is nonzero. The search skips queues that are not eligible, and no cell is served from them. The cells freed by an empty queue go to the active queues according to their weights.
- R4: A turn serves at most the queue's weight in cells. Each `cell_done` while `serve_valid` is 1 uses up one credit. The weight of queue i is `weight_flat[i*8 +: 8]`.
- R5: If a queue's `q_busy` bit drops during its turn, the turn ends and the remaining credit is discarded.
- R6: A queue whose weight is 0 never gets a turn, even while its `q_busy` bit is 1.
- R7: When every queue is empty or disabled, `serve_valid` is 0.
- R8: `serve_idx` holds its value until `cell_done` is seen. `cell_done` while `serve_valid` is 0 has no effect.
- R9: A change to a queue's weight during its turn does not alter that turn. The new weight is loaded when the queue's next turn starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_busy | input | NUM_Q | Per-queue non-empty flag, bit i for queue i |
| weight_flat | input | NUM_Q*WGT_W | Per-queue burst weight, queue i in bits [i*WGT_W +: WGT_W] |
| cell_done | input | 1 | One cell from the served queue has been sent |
| serve_idx | output | IDX_W | Queue currently allowed to send |
| serve_valid | output | 1 | `serve_idx` names a queue with a cell to send |

## Verification
The assertions assume that `cell_done` lasts one cycle for each cell and is raised only while `serve_valid` is 1. The exception is the deliberate pulses used to check that such a strobe is ignored. They also assume that a queue's `q_busy` bit drops only after the strobe that removed its last cell. The bench follows both rules: its queue-content model lowers a busy flag only at the falling edge after the cell is consumed, and it changes weights only at falling edges. A reference model of the round order computes, from the counts and weights, the full sequence of queue indices expected. A monitor then compares each served cell against that sequence.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    localparam int WGT_W = 8;

    typedef logic [WGT_W-1:0] wgt_t;

    typedef struct packed {
        logic hold;
        wgt_t credit;
    } turn_t;

    function automatic int wrap_add(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/wrr_elig.sv
module wrr_elig
    import wrr_pkg::*;
#(
    parameter int NUM_Q = 5
) (
    input  logic [NUM_Q-1:0]       q_busy,
    input  logic [NUM_Q*WGT_W-1:0] weight_flat,
    output logic [NUM_Q-1:0]       elig
);
    for (genvar g = 0; g < NUM_Q; g++) begin : g_elig
        assign elig[g] = q_busy[g] && (weight_flat[g*WGT_W +: WGT_W] != '0);
    end
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick
    import wrr_pkg::*;
#(
    parameter int NUM_Q = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] elig,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] pick_idx,
    output logic [NUM_Q-1:0] pick_oh
);
    always_comb begin
        found    = 1'b0;
        pick_idx = last_idx;
        for (int k = 0; k < NUM_Q; k++) begin
            int p;
            p = wrap_add(int'(last_idx), k + 1, NUM_Q);
            if (!found && elig[p]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(p);
            end
        end
        pick_oh = '0;
        if (found) pick_oh[pick_idx] = 1'b1;
    end

    // R2
    pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick_oh));

    // R3
    pick_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> ((pick_oh & elig) != '0));
endmodule

// File: rtl/wrr_turn.sv
module wrr_turn
    import wrr_pkg::*;
#(
    parameter int NUM_Q = 5,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_Q-1:0]       q_busy,
    input  logic [NUM_Q*WGT_W-1:0] weight_flat,
    input  logic                   cell_done,
    input  logic                   found,
    input  logic [IDX_W-1:0]       pick_idx,
    output logic [IDX_W-1:0]       cur_q,
    output logic                   serve_valid
);
    turn_t st;
    logic  cur_busy, take, last_cell, turn_over;
    wgt_t  pick_wgt;

    assign cur_busy    = q_busy[cur_q];
    assign serve_valid = st.hold && cur_busy;
    assign take        = serve_valid && cell_done;
    assign last_cell   = take && (st.credit == wgt_t'(1));
    assign turn_over   = !st.hold || !cur_busy || last_cell;
    assign pick_wgt    = weight_flat[pick_idx*WGT_W +: WGT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= IDX_W'(NUM_Q - 1);
            st.hold   <= 1'b0;
            st.credit <= '0;
        end else if (turn_over) begin
            if (found) begin
                cur_q     <= pick_idx;
                st.hold   <= 1'b1;
                st.credit <= pick_wgt;
            end else begin
                st.hold   <= 1'b0;
                st.credit <= '0;
            end
        end else if (take) begin
            st.credit <= st.credit - wgt_t'(1);
        end
    end

    // R4
    credit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !last_cell && st.hold && cur_busy) |=> (st.credit == $past(st.credit) - wgt_t'(1)));

    // R6
    credit_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        st.hold |-> (st.credit != '0));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (serve_valid && !cell_done) |=> (!serve_valid || $stable(cur_q)));
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int NUM_Q = 5,
    localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_Q-1:0]       q_busy,
    input  logic [NUM_Q*WGT_W-1:0] weight_flat,
    input  logic                   cell_done,
    output logic [IDX_W-1:0]       serve_idx,
    output logic                   serve_valid
);
    logic [NUM_Q-1:0] elig;
    logic [NUM_Q-1:0] pick_oh;
    logic             found;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] cur_q;

    wrr_elig #(.NUM_Q(NUM_Q)) elig_i (
        .q_busy(q_busy), .weight_flat(weight_flat), .elig(elig)
    );

    wrr_pick #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) pick_i (
        .clk(clk), .rst(rst), .elig(elig), .last_idx(cur_q),
        .found(found), .pick_idx(pick_idx), .pick_oh(pick_oh)
    );

    wrr_turn #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) turn_i (
        .clk(clk), .rst(rst), .q_busy(q_busy), .weight_flat(weight_flat),
        .cell_done(cell_done), .found(found), .pick_idx(pick_idx),
        .cur_q(cur_q), .serve_valid(serve_valid)
    );

    assign serve_idx = cur_q;

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|q_busy)) |-> !serve_valid);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !serve_valid || (|elig));
endmodule

// File: tb/wrr_sched_tb_top.sv
module wrr_sched_tb_top;
    localparam int NQ = 5;
    localparam int WW = 8;
    localparam int IW = 3;
    localparam int NEVER = 1 << 30;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic [NQ-1:0]    q_busy;
    logic [NQ*WW-1:0] weight_flat;
    logic             cell_done;
    logic [IW-1:0]    serve_idx;
    logic             serve_valid;

    int cnt[NQ];
    int wgt[NQ];
    int wnew[NQ];
    int switch_at;
    int m_last;
    int served;
    int exp_q[$];
    int checks = 0;
    int errors = 0;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_busy[i] = (cnt[i] != 0);
            weight_flat[i*WW +: WW] = WW'(wgt[i]);
        end
    end

    wrr_sched #(.NUM_Q(NQ)) dut_i (
        .clk(clk), .rst(rst), .q_busy(q_busy), .weight_flat(weight_flat),
        .cell_done(cell_done), .serve_idx(serve_idx), .serve_valid(serve_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver: predict the served sequence from counts and weights
    task automatic push_expected();
        int c[NQ];
        int s;
        s = 0;
        for (int i = 0; i < NQ; i++) c[i] = cnt[i];
        forever begin
            int nxt;
            int cr;
            nxt = -1;
            for (int k = 0; k < NQ; k++) begin
                int p;
                int w;
                p = (m_last + 1 + k) % NQ;
                w = (s >= switch_at) ? wnew[p] : wgt[p];
                if (nxt < 0 && c[p] > 0 && w > 0) nxt = p;
            end
            if (nxt < 0) break;
            m_last = nxt;
            cr = (s >= switch_at) ? wnew[nxt] : wgt[nxt];
            while (cr > 0 && c[nxt] > 0) begin
                exp_q.push_back(nxt);
                c[nxt]--;
                cr--;
                s++;
            end
        end
    endtask

    // monitor: pop and compare as cells are served
    task automatic drain(input string tag, input bit stall);
        int pend;
        int n;
        bit tog;
        pend = -1;
        n = 0;
        tog = 1'b0;
        served = 0;
        while (exp_q.size() > 0 && n < 4000) begin
            @(negedge clk);
            if (pend >= 0) begin
                cnt[pend]--;
                pend = -1;
            end
            cell_done = 1'b0;
            #1;
            n++;
            if (serve_valid) begin
                tog = !tog;
                if (stall && tog) begin
                    check(int'(serve_idx) == exp_q[0], "R8", "held index", int'(serve_idx), exp_q[0]);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(serve_idx) == e, tag, "served queue", int'(serve_idx), e);
                    cell_done = 1'b1;
                    pend = int'(serve_idx);
                    served++;
                    if (served == switch_at)
                        for (int i = 0; i < NQ; i++) wgt[i] = wnew[i];
                end
            end
        end
        @(negedge clk);
        if (pend >= 0) cnt[pend]--;
        cell_done = 1'b0;
        check(exp_q.size() == 0, tag, "cells left unserved", exp_q.size(), 0);
        exp_q.delete();
        switch_at = NEVER;
    endtask

    task automatic idle_check(input string tag);
        repeat (3) @(negedge clk);
        #1;
        check(serve_valid == 1'b0, tag, "valid when nothing eligible", int'(serve_valid), 0);
    endtask

    task automatic load(input int c0, input int c1, input int c2, input int c3, input int c4,
                        input int w0, input int w1, input int w2, input int w3, input int w4);
        @(negedge clk);
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3; cnt[4] = c4;
        wgt[0] = w0; wgt[1] = w1; wgt[2] = w2; wgt[3] = w3; wgt[4] = w4;
        push_expected();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cell_done = 1'b0;
        switch_at = NEVER;
        for (int i = 0; i < NQ; i++) begin
            cnt[i] = 0; wgt[i] = 1; wnew[i] = 1;
        end
        cnt[0] = 3;
        repeat (3) @(negedge clk);
        #1;
        check(serve_valid == 1'b0, "R1", "valid during reset", int'(serve_valid), 0);
        cnt[0] = 0;
        @(negedge clk);
        rst = 1'b0;
        m_last = NQ - 1;
        #1;
        check(serve_valid == 1'b0, "R1", "valid after reset", int'(serve_valid), 0);

        // R1 R2 R4: all busy, first turn at queue 0, full rounds then tails
        load(25, 25, 25, 25, 25, 1, 2, 4, 7, 10);
        drain("R2", 1'b0);
        idle_check("R7");

        // R3: queue 4 idle, its share goes to the rest
        load(12, 12, 12, 12, 0, 1, 2, 4, 7, 10);
        drain("R3", 1'b0);

        // R6: zero weights disable busy queues
        load(4, 5, 4, 5, 4, 3, 0, 2, 0, 1);
        drain("R6", 1'b0);
        idle_check("R6");

        // R5: turns cut short when a queue runs dry
        load(1, 2, 0, 3, 1, 5, 5, 5, 5, 5);
        drain("R5", 1'b0);
        idle_check("R5");

        // R8: index holds while cell_done is withheld
        load(3, 0, 4, 2, 0, 2, 2, 3, 2, 2);
        drain("R8", 1'b1);

        // R8: cell_done while idle is ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cell_done = 1'b1;
            #1;
            check(serve_valid == 1'b0, "R8", "valid after idle strobe", int'(serve_valid), 0);
        end
        @(negedge clk);
        cell_done = 1'b0;
        load(0, 0, 3, 0, 0, 1, 1, 4, 1, 1);
        drain("R8", 1'b0);

        // R9: weight drop during a turn applies from the next turn
        @(negedge clk);
        for (int i = 0; i < NQ; i++) wnew[i] = 3;
        wnew[0] = 1;
        switch_at = 1;
        load(7, 7, 0, 0, 0, 3, 3, 3, 3, 3);
        switch_at = 1;
        drain("R9", 1'b0);

        // R2: a lone queue takes consecutive turns
        load(0, 0, 0, 6, 0, 1, 1, 1, 2, 1);
        drain("R2", 1'b0);
        idle_check("R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule